// File: doc/BRIEF.md
# Flow-Controlled Test Sequence Generator

This block drives a single streaming output with a known test pattern for link and datapath diagnostics. Software-facing control is handled elsewhere. The block receives an enable, a one-bit pattern select and a 32-bit seed word. A downstream request input paces it, and it emits a new data word with a valid strobe for each request it accepts.

Two patterns are available. The first is a counting sequence that starts at the seed. The second is a maximal-length linear feedback shift register (LFSR) sequence seeded from the seed word. Alongside the data, the block keeps a running count of the valid words it has sent since it was last enabled. A rising count tells an observer that traffic is flowing.

While the enable is low, the generator stays parked. It holds the reloaded seed and a zero count, so the next enable restarts the pattern from the beginning.

Top module: `diag_seq_gen`

## Requirements
- R1: After asynchronous reset (rst_ni low), val_o is 0, dat_o is all zeros and cnt_o is 0.
- R2: At each clock edge where en_i is low, the next val_o is 0, cnt_o becomes 0, and the sequence state is reloaded from the seed. The first word after re-enabling is therefore the seed-derived start value again.
- R3: DATA_W may be 1 to 32. The sequence uses only the low DATA_W bits of the 32-bit seed_i, and the upper seed bits are dropped.
- R4: With sel_i = 0, successive valid words are seed, seed+1, seed+2 and so on, modulo 2^DATA_W.
- R5: With sel_i = 1, each step shifts the state left by one bit. The XOR of the tapped bits enters bit 0, and the tap mask is fixed per width; for DATA_W = 8 the mask is 0xB8. The sequence has period 2^DATA_W - 1. A seed whose low DATA_W bits are zero is replaced by 1.
- R6: A word is issued only at an edge where en_i and req_i are both high. At any other edge the next val_o is 0, and both dat_o and the sequence state hold their values.
- R7: cnt_o increases by one in the same cycle that each valid word appears on dat_o. It wraps modulo 2^CNT_W, with a default width of 32 bits.
- R8: val_o is registered. It is 1 exactly in the cycle after an edge at which en_i and req_i were both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable; low parks and clears |
| sel_i | input | 1 | Pattern select: 0 counting, 1 LFSR |
| seed_i | input | 32 | Seed word, resized to DATA_W |
| req_i | input | 1 | Downstream request / ready |
| dat_o | output | DATA_W | Sequence data word |
| val_o | output | 1 | Data valid strobe |
| cnt_o | output | CNT_W | Valid words sent since enable |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 4. The narrow data width lets the counting pattern wrap past 0xFF within a few words. It also makes seed truncation visible with a wide seed, and it lets a full LFSR period of 255 steps be walked and checked against an independent model. The 4-bit count wraps after 16 words, which puts the modulo behaviour of the transmit counter within reach of a short run.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;

  // Fibonacci feedback masks, bit (t-1) set for tap t; maximal length per width.
  function automatic logic [31:0] lfsr_mask(input int unsigned w);
    case (w)
      2:  return 32'h0000_0003;
      3:  return 32'h0000_0006;
      4:  return 32'h0000_000C;
      5:  return 32'h0000_0014;
      6:  return 32'h0000_0030;
      7:  return 32'h0000_0060;
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0829;
      13: return 32'h0000_100D;
      14: return 32'h0000_2015;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      17: return 32'h0001_2000;
      18: return 32'h0002_0400;
      19: return 32'h0004_0023;
      20: return 32'h0009_0000;
      21: return 32'h0014_0000;
      22: return 32'h0030_0000;
      23: return 32'h0042_0000;
      24: return 32'h00E1_0000;
      25: return 32'h0120_0000;
      26: return 32'h0200_0023;
      27: return 32'h0400_0013;
      28: return 32'h0900_0000;
      29: return 32'h1400_0000;
      30: return 32'h2000_0029;
      31: return 32'h4800_0000;
      32: return 32'h8020_0003;
      default: return 32'h0000_0001;
    endcase
  endfunction

  typedef enum logic {
    SEQ_COUNT = 1'b0,
    SEQ_LFSR  = 1'b1
  } seq_kind_e;

endpackage

// File: rtl/diag_seq_step.sv
module diag_seq_step
  import diag_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] cur_i,
  input  seq_kind_e         kind_i,
  output logic [DATA_W-1:0] nxt_o
);

  localparam logic [31:0] MASK_FULL = lfsr_mask(DATA_W);
  localparam logic [DATA_W-1:0] MASK = MASK_FULL[DATA_W-1:0];

  logic [DATA_W-1:0] inc_nxt;
  logic [DATA_W-1:0] lfsr_nxt;

  assign inc_nxt = cur_i + DATA_W'(1);

  generate
    if (DATA_W == 1) begin : g_lfsr_w1
      // single-bit register: only non-zero state is 1, period 1
      assign lfsr_nxt = cur_i;
    end else begin : g_lfsr_wn
      logic fb;
      assign fb       = ^(cur_i & MASK);
      assign lfsr_nxt = {cur_i[DATA_W-2:0], fb};
    end
  endgenerate

  assign nxt_o = (kind_i == SEQ_LFSR) ? lfsr_nxt : inc_nxt;

endmodule

// File: rtl/diag_seq_core.sv
module diag_seq_core
  import diag_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  seq_kind_e         kind_i,
  input  logic [31:0]       seed_i,
  input  logic              req_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              val_o
);

  logic [DATA_W-1:0] state_q;
  logic [DATA_W-1:0] state_nxt;
  logic [DATA_W-1:0] seed_fit;
  logic [DATA_W-1:0] load_val;
  logic              issue;

  assign seed_fit = seed_i[DATA_W-1:0];
  // LFSR cannot leave all-zero; substitute 1
  assign load_val = (kind_i == SEQ_LFSR && seed_fit == '0) ? DATA_W'(1) : seed_fit;
  assign issue    = en_i & req_i;

  diag_seq_step #(.DATA_W(DATA_W)) u_step (
    .cur_i (state_q),
    .kind_i(kind_i),
    .nxt_o (state_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      dat_o   <= '0;
      val_o   <= 1'b0;
    end else if (!en_i) begin
      state_q <= load_val;
      val_o   <= 1'b0;
    end else if (issue) begin
      dat_o   <= state_q;
      state_q <= state_nxt;
      val_o   <= 1'b1;
    end else begin
      val_o   <= 1'b0;
    end
  end

  assert_lfsr_load_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && kind_i == SEQ_LFSR) |=> (state_q != '0));

  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !req_i) |=> ($stable(dat_o) && $stable(state_q)));

  assert_count_pattern_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i && kind_i == SEQ_COUNT && val_o && $past(kind_i) == SEQ_COUNT)
      |=> (dat_o == $past(dat_o) + DATA_W'(1)));

  assert_valid_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i) |=> val_o);

endmodule

// File: rtl/diag_tx_counter.sv
module diag_tx_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/diag_seq_gen.sv
module diag_seq_gen
  import diag_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic [31:0]       seed_i,
  input  logic              req_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              val_o,
  output logic [CNT_W-1:0]  cnt_o
);

  generate
    if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W out of range 1..32");
    end
  endgenerate

  seq_kind_e kind;
  assign kind = seq_kind_e'(sel_i);

  diag_seq_core #(.DATA_W(DATA_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .kind_i(kind),
    .seed_i(seed_i),
    .req_i (req_i),
    .dat_o (dat_o),
    .val_o (val_o)
  );

  diag_tx_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~en_i),
    .inc_i (en_i & req_i),
    .cnt_o (cnt_o)
  );

  assert_cnt_tracks_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_o |-> (cnt_o == $past(cnt_o) + CNT_W'(1) || $past(!en_i)));

  assert_no_valid_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !val_o);

endmodule

// File: tb/tb_diag_seq_gen.sv
`timescale 1ns/1ps
module tb_diag_seq_gen;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = 4;
  localparam int unsigned NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, sel = 1'b0, req = 1'b0;
  logic [31:0]   seed = 32'h0;
  logic [DW-1:0] dat;
  logic          val;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  diag_seq_gen #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_i(sel),
    .seed_i(seed), .req_i(req), .dat_o(dat), .val_o(val), .cnt_o(cnt)
  );

  // {en, req, sel, seed[31:0], exp_val, exp_dat[7:0], exp_cnt[3:0]}
  localparam logic [47:0] VEC [NV] = '{
    {3'b000, 32'h1234_5678, 1'b0, 8'h00, 4'd0},  // R2 park, R3 seed -> 0x78
    {3'b110, 32'h1234_5678, 1'b1, 8'h78, 4'd1},  // R4 R8 first word
    {3'b110, 32'h1234_5678, 1'b1, 8'h79, 4'd2},  // R4
    {3'b100, 32'h1234_5678, 1'b0, 8'h79, 4'd2},  // R6 hold
    {3'b110, 32'h1234_5678, 1'b1, 8'h7A, 4'd3},  // R6 resume
    {3'b010, 32'h1234_5678, 1'b0, 8'h7A, 4'd0},  // R2 clear
    {3'b110, 32'h1234_5678, 1'b1, 8'h78, 4'd1},  // R2 reload
    {3'b000, 32'h0000_00FF, 1'b0, 8'h78, 4'd0},
    {3'b110, 32'h0000_00FF, 1'b1, 8'hFF, 4'd1},
    {3'b110, 32'h0000_00FF, 1'b1, 8'h00, 4'd2},  // R4 wrap
    {3'b001, 32'hABCD_EF00, 1'b0, 8'h00, 4'd0},  // R5 zero seed
    {3'b111, 32'hABCD_EF00, 1'b1, 8'h01, 4'd1},  // R5 substituted 1
    {3'b111, 32'hABCD_EF00, 1'b1, 8'h02, 4'd2},
    {3'b111, 32'hABCD_EF00, 1'b1, 8'h04, 4'd3},
    {3'b111, 32'hABCD_EF00, 1'b1, 8'h08, 4'd4},
    {3'b111, 32'hABCD_EF00, 1'b1, 8'h11, 4'd5}   // R5 feedback
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic e, input logic r, input logic s, input logic [31:0] sd);
    @(negedge clk);
    en = e; req = r; sel = s; seed = sd;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] lfsr_ref(input logic [DW-1:0] x);
    return {x[DW-2:0], ^(x & 8'hB8)};
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] ref_st;
    logic [DW-1:0] first;
    logic [CW-1:0] exp_c;
    #12;
    check("R1 val", 32'(val), 32'd0);
    check("R1 dat", 32'(dat), 32'd0);
    check("R1 cnt", 32'(cnt), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      drive(v[47], v[46], v[45], v[44:13]);
      check($sformatf("R8/R6 vec%0d val", i), 32'(val), 32'(v[12]));
      check($sformatf("R4/R5 vec%0d dat", i), 32'(dat), 32'(v[11:4]));
      check($sformatf("R7 vec%0d cnt", i), 32'(cnt), 32'(v[3:0]));
    end

    // R5: full LFSR period from seed 0x5A, checked against an independent model
    drive(1'b0, 1'b0, 1'b1, 32'hFFFF_FF5A);
    ref_st = 8'h5A;
    first  = 8'h5A;
    exp_c  = '0;
    for (int k = 0; k < 255; k++) begin
      drive(1'b1, 1'b1, 1'b1, 32'hFFFF_FF5A);
      exp_c = exp_c + CW'(1);
      if (dat !== ref_st) check("R5 lfsr step", 32'(dat), 32'(ref_st));
      if (cnt !== exp_c)  check("R7 wrap count", 32'(cnt), 32'(exp_c));
      ref_st = lfsr_ref(ref_st);
      if (k < 254 && ref_st == first) check("R5 short period", 32'(k), 32'd254);
    end
    check("R5 period returns to seed", 32'(ref_st), 32'(first));
    drive(1'b1, 1'b1, 1'b1, 32'hFFFF_FF5A);
    check("R5 word after full period", 32'(dat), 32'(first));
    check("R7 cnt wraps mod 16", 32'(cnt), 32'(256 % 16));

    // R6: request gaps do not advance the sequence
    drive(1'b0, 1'b0, 1'b0, 32'h0000_0010);
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, k[0], 1'b0, 32'h0000_0010);
      check("R8 val on alternate req", 32'(val), 32'(k[0]));
    end
    check("R6 three issues only", 32'(dat), 32'h12);
    check("R7 count three", 32'(cnt), 32'd3);

    // R1: reset mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async val", 32'(val), 32'd0);
    check("R1 async cnt", 32'(cnt), 32'd0);
    check("R1 async dat", 32'(dat), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end

endmodule